// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date as seven packed-BCD fields: seconds, minutes, hours (24-hour), day of week, day of month, month and a two-digit year. Each one-second tick enable advances the seconds. Carries then ripple upward through the fields in the same cycle. The day-of-month limit follows the current month, and February gains a 29th day in leap years.

A parallel load port writes all seven fields in one cycle. A load wins over a tick in the same cycle. A stop input freezes the count while ticks keep arriving. The host logic that makes the one-second tick, decodes bus accesses and buffers registers sits outside this block and uses the seven BCD outputs directly.

Top module: `bcd_cal_counter`

## Requirements
- R1: Seconds advance by one on each accepted tick and cover 00 to 59. From 59 they return to 00 and advance minutes in the same cycle.
- R2: Minutes cover 00 to 59. From 59 with a seconds carry they return to 00 and advance hours.
- R3: Hours cover 00 to 23. From 23 with a minutes carry they return to 00, which is the midnight rollover.
- R4: Day of week covers 01 to 07 and advances only at the midnight rollover. From 07 it returns to 01.
- R5: At the midnight rollover the date returns to 01 and the month advances once the date has reached the month's last day. The last day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For February it is 28, or 29 in a leap year. Before that day the date just increments.
- R6: A year is a leap year when its two-digit value is divisible by 4, and this includes 00 (2000, and 2100 is out of range).
- R7: Month covers 01 to 12. From 12 with a date carry it returns to 01 and the year advances. Year covers 00 to 99 and wraps from 99 to 00.
- R8: While stop_i is 1, ticks have no effect and every field holds its value. Counting resumes on the first tick after stop_i returns to 0.
- R9: When load_i is 1, every field takes its load input on the next clock edge. This happens whether or not tick_i or stop_i is set in that cycle.
- R10: Asynchronous reset gives 00:00:00, day of week 01, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance enable |
| stop_i | input | 1 | Freezes counting while 1 |
| load_i | input | 1 | Loads all fields from the ld_* inputs |
| ld_sec_i | input | 8 | Seconds load value, BCD |
| ld_min_i | input | 8 | Minutes load value, BCD |
| ld_hour_i | input | 8 | Hours load value, BCD |
| ld_dow_i | input | 8 | Day-of-week load value, BCD |
| ld_date_i | input | 8 | Date load value, BCD |
| ld_month_i | input | 8 | Month load value, BCD |
| ld_year_i | input | 8 | Year load value, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| dow_o | output | 8 | Day of week, BCD |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
A long run of plain ticks from midnight crosses every seconds and minutes digit boundary and an hour carry. This separates correct BCD digit carries from binary counting.

Single ticks from 23:59:59 on the last day of each of the twelve months check the month-length table. Ticks from the 30th of a 31-day month show that the date increments rather than wrapping early. February is tried in years 23, 24 and 00, which separates the divisible-by-4 rule from a rule that treats 00 as non-leap. Loads issued together with a tick, and loads issued while stopped, show that load has priority over both.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int DIGIT_W    = FIELD_W / 2;

  // field indices, ordered by carry chain
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  typedef logic [FIELD_W-1:0] bcd_t;

  function automatic bcd_t bcd_inc(input bcd_t v);
    bcd_t r;
    if (v[DIGIT_W-1:0] >= DIGIT_W'(9)) begin
      r[DIGIT_W-1:0]       = '0;
      r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W] + DIGIT_W'(1);
    end else begin
      r[DIGIT_W-1:0]       = v[DIGIT_W-1:0] + DIGIT_W'(1);
      r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W];
    end
    return r;
  endfunction

  function automatic bcd_t field_low(input int idx);
    case (idx)
      F_DOW, F_DATE, F_MONTH: return bcd_t'(8'h01);
      default:                return bcd_t'(8'h00);
    endcase
  endfunction

  function automatic bcd_t field_fixed_limit(input int idx);
    case (idx)
      F_SEC, F_MIN: return bcd_t'(8'h59);
      F_HOUR:       return bcd_t'(8'h23);
      F_DOW:        return bcd_t'(8'h07);
      F_MONTH:      return bcd_t'(8'h12);
      F_YEAR:       return bcd_t'(8'h99);
      default:      return bcd_t'(8'h31);
    endcase
  endfunction
endpackage

// File: rtl/cal_leap_year.sv
module cal_leap_year
  import cal_pkg::*;
(
  input  bcd_t year_i,
  output logic leap_o
);
  logic [DIGIT_W-1:0] tens, ones;
  assign tens = year_i[FIELD_W-1:DIGIT_W];
  assign ones = year_i[DIGIT_W-1:0];

  // (10*t + o) mod 4 == (2*t + o) mod 4
  always_comb begin
    if (tens[0])
      leap_o = (ones == DIGIT_W'(2)) || (ones == DIGIT_W'(6));
    else
      leap_o = (ones == DIGIT_W'(0)) || (ones == DIGIT_W'(4)) || (ones == DIGIT_W'(8));
  end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  bcd_t month_i,
  input  bcd_t year_i,
  output bcd_t last_date_o
);
  logic leap;

  cal_leap_year u_leap (
    .year_i (year_i),
    .leap_o (leap)
  );

  always_comb begin
    case (month_i)
      8'h02:                      last_date_o = leap ? bcd_t'(8'h29) : bcd_t'(8'h28);
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = bcd_t'(8'h30);
      default:                    last_date_o = bcd_t'(8'h31);
    endcase
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter bcd_t LOW_VAL = 8'h00,
  parameter bcd_t RST_VAL = 8'h00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  bcd_t load_val_i,
  input  logic step_i,
  input  bcd_t limit_i,
  output bcd_t val_o,
  output logic carry_o
);
  bcd_t val_q;
  logic at_limit;

  // >= so that an out-of-range load recovers at the next step
  assign at_limit = (val_q >= limit_i);
  assign carry_o  = step_i && at_limit;
  assign val_o    = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= RST_VAL;
    else if (load_i)  val_q <= load_val_i;
    else if (step_i)  val_q <= at_limit ? LOW_VAL : bcd_inc(val_q);
  end
endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
  import cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       stop_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_dow_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_month_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  bcd_t ld_val [NUM_FIELDS];
  bcd_t cur    [NUM_FIELDS];
  bcd_t limit  [NUM_FIELDS];
  logic step   [NUM_FIELDS];
  logic carry  [NUM_FIELDS];
  logic advance;
  bcd_t last_date;

  assign ld_val[F_SEC]   = ld_sec_i;
  assign ld_val[F_MIN]   = ld_min_i;
  assign ld_val[F_HOUR]  = ld_hour_i;
  assign ld_val[F_DOW]   = ld_dow_i;
  assign ld_val[F_DATE]  = ld_date_i;
  assign ld_val[F_MONTH] = ld_month_i;
  assign ld_val[F_YEAR]  = ld_year_i;

  // load outranks tick and stop
  assign advance = tick_i && !stop_i && !load_i;

  // carry chain; day of week and date share the midnight carry
  assign step[F_SEC]   = advance;
  assign step[F_MIN]   = carry[F_SEC];
  assign step[F_HOUR]  = carry[F_MIN];
  assign step[F_DOW]   = carry[F_HOUR];
  assign step[F_DATE]  = carry[F_HOUR];
  assign step[F_MONTH] = carry[F_DATE];
  assign step[F_YEAR]  = carry[F_MONTH];

  cal_month_len u_mlen (
    .month_i     (cur[F_MONTH]),
    .year_i      (cur[F_YEAR]),
    .last_date_o (last_date)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (i == F_DATE) begin : g_dyn
      assign limit[i] = last_date;
    end else begin : g_fix
      assign limit[i] = field_fixed_limit(i);
    end

    cal_bcd_field #(
      .LOW_VAL (field_low(i)),
      .RST_VAL (field_low(i))
    ) u_field (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_i),
      .load_val_i (ld_val[i]),
      .step_i     (step[i]),
      .limit_i    (limit[i]),
      .val_o      (cur[i]),
      .carry_o    (carry[i])
    );
  end

  assign sec_o   = cur[F_SEC];
  assign min_o   = cur[F_MIN];
  assign hour_o  = cur[F_HOUR];
  assign dow_o   = cur[F_DOW];
  assign date_o  = cur[F_DATE];
  assign month_o = cur[F_MONTH];
  assign year_o  = cur[F_YEAR];
endmodule

// File: rtl/cal_counter_checker.sv
module cal_counter_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       stop_i,
  input logic       load_i,
  input logic [7:0] ld_sec_i,
  input logic [7:0] ld_min_i,
  input logic [7:0] ld_hour_i,
  input logic [7:0] ld_dow_i,
  input logic [7:0] ld_date_i,
  input logic [7:0] ld_month_i,
  input logic [7:0] ld_year_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (!tick_i || stop_i)) |=>
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(dow_o) &&
       $stable(date_o) && $stable(month_o) && $stable(year_o)));

  a_r9_load_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=>
      (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) && hour_o == $past(ld_hour_i) &&
       dow_o == $past(ld_dow_i) && date_o == $past(ld_date_i) &&
       month_o == $past(ld_month_i) && year_o == $past(ld_year_i)));

  a_r1_sec_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && !load_i) |=> (sec_o != $past(sec_o)));

  a_r2_min_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && !load_i && sec_o == 8'h59) |=> (min_o != $past(min_o)));

  a_r4_dow_with_date: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((date_o != $past(date_o)) == (dow_o != $past(dow_o))));

  a_r7_year_at_new_year: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (year_o == $past(year_o) || month_o == 8'h01));
endmodule

bind bcd_cal_counter cal_counter_checker u_chk (.*);

// File: tb/tb_bcd_cal_counter.sv
module tb_bcd_cal_counter;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, stop_i = 1'b0, load_i = 1'b0;
  logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_dow_i = '0;
  logic [7:0] ld_date_i = '0, ld_month_i = '0, ld_year_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;

  always #10 clk_i = ~clk_i;

  bcd_cal_counter dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model in binary
  int m_s = 0, m_mi = 0, m_h = 0, m_dw = 1, m_d = 1, m_mo = 1, m_y = 0;
  int n_s, n_mi, n_h, n_dw, n_d, n_mo, n_y;

  logic [55:0] exp_q[$];
  string       req_q[$];
  time         t_q[$];

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0;
          m_dw = (m_dw == 7) ? 1 : m_dw + 1;
          m_d++;
          if (m_d > days_in(m_mo, m_y)) begin
            m_d = 1; m_mo++;
            if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic set_load(input int y, mo, d, dw, h, mi, s);
    n_y = y; n_mo = mo; n_d = d; n_dw = dw; n_h = h; n_mi = mi; n_s = s;
  endtask

  // driver: one cycle of stimulus, pushes expected outputs after the edge
  task automatic cyc(input bit tk, input bit st, input bit ld, input string req);
    @(negedge clk_i);
    tick_i = tk; stop_i = st; load_i = ld;
    ld_sec_i = to_bcd(n_s); ld_min_i = to_bcd(n_mi); ld_hour_i = to_bcd(n_h);
    ld_dow_i = to_bcd(n_dw); ld_date_i = to_bcd(n_d); ld_month_i = to_bcd(n_mo);
    ld_year_i = to_bcd(n_y);
    if (ld) begin
      m_s = n_s; m_mi = n_mi; m_h = n_h; m_dw = n_dw; m_d = n_d; m_mo = n_mo; m_y = n_y;
    end else if (tk && !st) model_tick();
    exp_q.push_back({to_bcd(m_y), to_bcd(m_mo), to_bcd(m_d), to_bcd(m_dw),
                     to_bcd(m_h), to_bcd(m_mi), to_bcd(m_s)});
    req_q.push_back(req);
    t_q.push_back($time);
  endtask

  task automatic load_then_tick(input int y, mo, d, dw, h, mi, s, input int n, input string req);
    set_load(y, mo, d, dw, h, mi, s);
    cyc(0, 0, 1, "R9");
    repeat (n) cyc(1, 0, 0, req);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0 && t_q[0] < $time) begin
      logic [55:0] act, ex;
      string r;
      act = {year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
      ex = exp_q.pop_front();
      r = req_q.pop_front();
      void'(t_q.pop_front());
      checks++;
      if (act !== ex) begin
        fails++;
        $display("FAIL %s: got %h expected %h (y mo d dw h mi s)", r, act, ex);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    set_load(0, 1, 1, 1, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(0, 0, 0, "R10");  // reset values

    // R1 R2: long run across digit and minute/hour carries
    set_load(30, 6, 15, 3, 0, 0, 0);
    cyc(0, 0, 1, "R9");
    repeat (3700) cyc(1, 0, 0, "R1_R2");

    // R3 R4 R5: midnight, Feb in non-leap year, dow 07 -> 01
    load_then_tick(23, 2, 28, 7, 23, 59, 58, 3, "R3_R4_R5");

    // R6: leap years 24 and 00
    load_then_tick(24, 2, 28, 5, 23, 59, 59, 1, "R6");
    load_then_tick(24, 2, 29, 6, 23, 59, 59, 1, "R6");
    load_then_tick(0, 2, 28, 2, 23, 59, 59, 2, "R6");

    // R5: last day of each month, and the 30th of each 31-day month
    for (int mo = 1; mo <= 12; mo++) begin
      load_then_tick(21, mo, days_in(mo, 21), 4, 23, 59, 59, 1, "R5");
      if (days_in(mo, 21) == 31) load_then_tick(21, mo, 30, 4, 23, 59, 59, 1, "R5");
    end

    // R7: year advance and 99 -> 00
    load_then_tick(45, 12, 31, 1, 23, 59, 59, 1, "R7");
    load_then_tick(99, 12, 31, 7, 23, 59, 59, 2, "R7");

    // R8: stop freezes, then resumes
    load_then_tick(50, 7, 4, 2, 12, 34, 56, 2, "R8");
    repeat (6) cyc(1, 1, 0, "R8");
    repeat (3) cyc(1, 0, 0, "R8");

    // R9: load with tick, load while stopped
    set_load(11, 11, 11, 4, 11, 11, 11);
    cyc(1, 0, 1, "R9");
    set_load(88, 8, 8, 6, 8, 8, 8);
    cyc(1, 1, 1, "R9");
    cyc(1, 1, 0, "R9");

    @(negedge clk_i);
    tick_i = 0; stop_i = 0; load_i = 0;
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule